// File: doc/BRIEF.md
# SDRAM Start-up Command Sequencer

This block owns the command pins of a single-data-rate synchronous DRAM from reset until the memory can accept ordinary traffic. On leaving reset it drives no-operation while a power-stable interval runs, and keeps driving it through a settling delay of at least 200 µs. It then closes every bank with a precharge-all, waits out the precharge recovery time, and issues a parameterized number of auto-refresh commands. Refreshes are spaced by the row cycle time. Last, it writes a parameterized value into the mode register and raises a completion flag.

All timing is given in physical units (microseconds or nanoseconds) together with the clock frequency. Each value is turned into a cycle count at elaboration. Clock enable and the data mask stay high the whole time, so the memory's data outputs stay high-impedance. A memory controller holds off its own traffic until the completion flag is high. The flag then stays high until the next synchronous reset, and that reset restarts the whole sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is sampled high, and in the cycle after it, the outputs are: command NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), addr = 0, ba = 0 and done = 0.
- R2: Let W = PWR_CYC + SETTLE_CYC, where PWR_CYC = ceil(T_PWR_US·f/1000) and SETTLE_CYC = ceil(T_SETTLE_US·f/1000), with f = CLK_FREQ_KHZ. Number the cycles after the last reset edge from 0. Cycles 0 to W-1 carry NOP with addr = 0 and ba = 0.
- R3: In cycle W the command is precharge (4'b0010) with addr bit 10 high, every other addr bit low, and ba = 0.
- R4: The first auto-refresh comes RP cycles after the precharge, where RP = max(2, ceil(T_RP_NS·f/10^6)). The cycles in between carry NOP.
- R5: Exactly N_REFRESH auto-refresh commands (4'b0001, addr 0, ba 0) are issued, each RC cycles after the one before it, where RC = max(2, ceil(T_RC_NS·f/10^6)). Elaboration rejects an N_REFRESH below 8.
- R6: The mode-register-set command (4'b0000) comes RC cycles after the last refresh. It carries addr = MODE_VALUE and ba = 0.
- R7: done rises MRD = max(2, T_MRD_CYC) cycles after the mode-register-set. It stays high and the command stays NOP until reset.
- R8: cke is 1 and every dqm bit is 1 in every cycle.
- R9: A reset at any point, including after done has risen, clears done and restarts the sequence from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Clock enable to the memory, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (bit 10 selects all banks for precharge; carries the mode value) |
| ba | output | BA_W | Bank address, always zero here |
| dqm | output | DQM_W | Data mask, held high |
| done | output | 1 | Start-up sequence complete, sticky until reset |

## Verification
Any corruption of the phase register or of the interval counter shows on the pins as a command in the wrong cycle. A bench that predicts the exact cycle of every command catches it within one clock of the first moved command. A refresh counter that is off by one moves the mode-register-set by a whole RC and adds or drops a refresh. This shows up at the first refresh slot that differs. A wrong decode of the phase shows up at once as a wrong pin pattern or address, because both are compared on every cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [2:0] {
      PH_WAIT,
      PH_PRE,
      PH_TRP,
      PH_REF,
      PH_TRC,
      PH_MRS,
      PH_TMRD,
      PH_DONE
   } phase_t;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_NOP = 4'b0111;
   localparam logic [3:0] CMD_PRE = 4'b0010;
   localparam logic [3:0] CMD_REF = 4'b0001;
   localparam logic [3:0] CMD_MRS = 4'b0000;

   // ceil(amount * khz / div)
   function automatic int unsigned to_cycles(input longint unsigned amount,
                                             input longint unsigned khz,
                                             input longint unsigned div);
      longint unsigned prod;
      prod = amount * khz;
      return int'((prod + div - 1) / div);
   endfunction

   function automatic int unsigned at_least_two(input int unsigned v);
      return (v < 2) ? 2 : v;
   endfunction

   function automatic int unsigned max3(input int unsigned a,
                                        input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (load) begin
         remain <= load_val;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign expired = (remain == '0);

endmodule

// File: rtl/sdram_init_refcnt.sv
module sdram_init_refcnt #(
   parameter int unsigned TARGET = 8
) (
   input  logic clk,
   input  logic clear,
   input  logic bump,
   output logic reached
);

   localparam int unsigned CW = $clog2(TARGET + 1);

   logic [CW-1:0] issued;

   always_ff @(posedge clk) begin
      if (clear) begin
         issued <= '0;
      end else if (bump) begin
         issued <= issued + 1'b1;
      end
   end

   assign reached = (issued == CW'(TARGET));

endmodule

// File: rtl/sdram_init_cmdenc.sv
module sdram_init_cmdenc
   import sdram_init_pkg::*;
#(
   parameter int unsigned         ADDR_W     = 13,
   parameter int unsigned         BA_W       = 2,
   parameter logic [ADDR_W-1:0]   MODE_VALUE = '0
) (
   input  phase_t            phase,
   output logic [3:0]        cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba
);

   localparam int unsigned ALLBANK_BIT = 10;

   logic [ADDR_W-1:0] pre_addr;

   generate
      if (ADDR_W == ALLBANK_BIT + 1) begin : g_top_bit
         assign pre_addr = {1'b1, {ALLBANK_BIT{1'b0}}};
      end else begin : g_mid_bit
         assign pre_addr = {{(ADDR_W-ALLBANK_BIT-1){1'b0}}, 1'b1, {ALLBANK_BIT{1'b0}}};
      end
   endgenerate

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      ba   = '0;
      unique case (phase)
         PH_PRE: begin
            cmd  = CMD_PRE;
            addr = pre_addr;
         end
         PH_REF: cmd = CMD_REF;
         PH_MRS: begin
            cmd  = CMD_MRS;
            addr = MODE_VALUE;
         end
         default: cmd = CMD_NOP;
      endcase
   end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int unsigned       CLK_FREQ_KHZ = 100000,
   parameter int unsigned       T_PWR_US     = 1,
   parameter int unsigned       T_SETTLE_US  = 200,
   parameter int unsigned       T_RP_NS      = 20,
   parameter int unsigned       T_RC_NS      = 70,
   parameter int unsigned       T_MRD_CYC    = 2,
   parameter int unsigned       N_REFRESH    = 8,
   parameter int unsigned       ADDR_W       = 13,
   parameter int unsigned       BA_W         = 2,
   parameter int unsigned       DQM_W        = 2,
   parameter logic [ADDR_W-1:0] MODE_VALUE   = 13'h0030
) (
   input  logic              clk,
   input  logic              rst,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic [DQM_W-1:0]  dqm,
   output logic              done
);

   localparam int unsigned PWR_CYC    = to_cycles(T_PWR_US, CLK_FREQ_KHZ, 1000);
   localparam int unsigned SETTLE_CYC = to_cycles(T_SETTLE_US, CLK_FREQ_KHZ, 1000);
   localparam int unsigned WAIT_CYC   = PWR_CYC + SETTLE_CYC;
   localparam int unsigned RP_CYC     = at_least_two(to_cycles(T_RP_NS, CLK_FREQ_KHZ, 1000000));
   localparam int unsigned RC_CYC     = at_least_two(to_cycles(T_RC_NS, CLK_FREQ_KHZ, 1000000));
   localparam int unsigned MRD_CYC    = at_least_two(T_MRD_CYC);
   localparam int unsigned TMAX       = max3(WAIT_CYC, RP_CYC, max3(RC_CYC, MRD_CYC, 1));
   localparam int unsigned CNT_W      = (TMAX < 2) ? 1 : $clog2(TMAX);

   // elaboration-time parameter checks
   generate
      if (N_REFRESH < 8) begin : g_bad_refresh
         $error("sdram_init_seq: N_REFRESH must be at least 8");
      end
      if (ADDR_W < 11) begin : g_bad_addr
         $error("sdram_init_seq: ADDR_W must reach bit 10");
      end
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("sdram_init_seq: start-up wait converts to zero cycles");
      end
      if (BA_W < 1 || DQM_W < 1) begin : g_bad_width
         $error("sdram_init_seq: BA_W and DQM_W must be positive");
      end
   endgenerate

   phase_t           phase, phase_nxt;
   logic             t_load;
   logic [CNT_W-1:0] t_val;
   logic             t_expired;
   logic             refs_reached;
   logic [3:0]       cmd;

   sdram_init_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk      (clk),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired)
   );

   sdram_init_refcnt #(
      .TARGET (N_REFRESH)
   ) i_refcnt (
      .clk     (clk),
      .clear   (rst),
      .bump    (phase == PH_REF),
      .reached (refs_reached)
   );

   always_comb begin
      phase_nxt = phase;
      t_load    = 1'b0;
      t_val     = '0;
      if (rst) begin
         phase_nxt = PH_WAIT;
         t_load    = 1'b1;
         t_val     = CNT_W'(WAIT_CYC - 1);
      end else begin
         unique case (phase)
            PH_WAIT: if (t_expired) phase_nxt = PH_PRE;
            PH_PRE: begin
               phase_nxt = PH_TRP;
               t_load    = 1'b1;
               t_val     = CNT_W'(RP_CYC - 2);
            end
            PH_TRP:  if (t_expired) phase_nxt = PH_REF;
            PH_REF: begin
               phase_nxt = PH_TRC;
               t_load    = 1'b1;
               t_val     = CNT_W'(RC_CYC - 2);
            end
            PH_TRC: begin
               if (t_expired) phase_nxt = refs_reached ? PH_MRS : PH_REF;
            end
            PH_MRS: begin
               phase_nxt = PH_TMRD;
               t_load    = 1'b1;
               t_val     = CNT_W'(MRD_CYC - 2);
            end
            PH_TMRD: if (t_expired) phase_nxt = PH_DONE;
            default: phase_nxt = PH_DONE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      phase <= phase_nxt;
   end

   sdram_init_cmdenc #(
      .ADDR_W     (ADDR_W),
      .BA_W       (BA_W),
      .MODE_VALUE (MODE_VALUE)
   ) i_cmdenc (
      .phase (phase),
      .cmd   (cmd),
      .addr  (addr),
      .ba    (ba)
   );

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign cke  = 1'b1;
   assign dqm  = '1;
   assign done = (phase == PH_DONE);

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
   parameter int unsigned       ADDR_W     = 13,
   parameter int unsigned       BA_W       = 2,
   parameter int unsigned       DQM_W      = 2,
   parameter logic [ADDR_W-1:0] MODE_VALUE = '0
) (
   input logic              clk,
   input logic              rst,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic [BA_W-1:0]   ba,
   input logic [DQM_W-1:0]  dqm,
   input logic              done
);

   logic [3:0] pins;
   assign pins = {cs_n, ras_n, cas_n, we_n};

   // R1: a reset edge leaves a NOP and done low
   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (pins == 4'b0111 && !done && addr == '0));

   // R3: precharge selects all banks in bank zero
   a_r3_pre_allbanks: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0010) |-> (addr[10] && $countones(addr) == 1 && ba == '0));

   // R5: a refresh is always followed by a NOP
   a_r5_ref_then_nop: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0001) |=> (pins == 4'b0111));

   // R6: mode-register-set carries the mode value
   a_r6_mrs_value: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0000) |-> (addr == MODE_VALUE && ba == '0));

   // R7: done is sticky and quiet
   a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
      done |=> done);
   a_r7_done_nop: assert property (@(posedge clk) disable iff (rst)
      done |-> (pins == 4'b0111));

   // R8: output buffers kept disabled
   a_r8_cke_dqm_high: assert property (@(posedge clk) disable iff (rst)
      (cke && (&dqm)));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
   .ADDR_W     (ADDR_W),
   .BA_W       (BA_W),
   .DQM_W      (DQM_W),
   .MODE_VALUE (MODE_VALUE)
) i_sdram_init_seq_chk (
   .clk   (clk),
   .rst   (rst),
   .cke   (cke),
   .cs_n  (cs_n),
   .ras_n (ras_n),
   .cas_n (cas_n),
   .we_n  (we_n),
   .addr  (addr),
   .ba    (ba),
   .dqm   (dqm),
   .done  (done)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

   localparam time CLK_PERIOD = 10ns;

   localparam int unsigned F_KHZ    = 100000;
   localparam int unsigned PWR_US   = 1;
   localparam int unsigned SET_US   = 200;
   localparam int unsigned RP_NS    = 30;
   localparam int unsigned RC_NS    = 70;
   localparam int unsigned MRD_IN   = 2;
   localparam int unsigned NREF     = 9;
   localparam int unsigned AW       = 13;
   localparam logic [AW-1:0] MODEV  = 13'h0232;

   // model timing, straight from the requirement formulas
   localparam int W_EXP   = (PWR_US * F_KHZ + 999) / 1000 + (SET_US * F_KHZ + 999) / 1000;
   localparam int RP_RAW  = (RP_NS * F_KHZ + 999999) / 1000000;
   localparam int RC_RAW  = (RC_NS * F_KHZ + 999999) / 1000000;
   localparam int RP_EXP  = (RP_RAW < 2) ? 2 : RP_RAW;
   localparam int RC_EXP  = (RC_RAW < 2) ? 2 : RC_RAW;
   localparam int MRD_EXP = (MRD_IN < 2) ? 2 : MRD_IN;
   localparam int MRS_AT  = W_EXP + RP_EXP + NREF * RC_EXP;
   localparam int DONE_AT = MRS_AT + MRD_EXP;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cke, cs_n, ras_n, cas_n, we_n, done;
   logic [AW-1:0] addr;
   logic [1:0]    ba;
   logic [1:0]    dqm;

   int errors = 0;
   int checks = 0;
   int idx    = 0;
   bit armed  = 1'b0;
   bit reset_seen = 1'b0;

   sdram_init_seq #(
      .CLK_FREQ_KHZ (F_KHZ),
      .T_PWR_US     (PWR_US),
      .T_SETTLE_US  (SET_US),
      .T_RP_NS      (RP_NS),
      .T_RC_NS      (RC_NS),
      .T_MRD_CYC    (MRD_IN),
      .N_REFRESH    (NREF),
      .ADDR_W       (AW),
      .MODE_VALUE   (MODEV)
   ) i_sdram_init_seq (
      .clk   (clk),
      .rst   (rst),
      .cke   (cke),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .addr  (addr),
      .ba    (ba),
      .dqm   (dqm),
      .done  (done)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // reference cycle index: 0 in the cycle after a reset edge
   always @(posedge clk) begin
      if (rst) begin
         idx        <= 0;
         reset_seen <= 1'b1;
      end else begin
         idx <= idx + 1;
      end
      armed <= 1'b1;
   end

   task automatic expect_at(input int i, output logic [3:0] c, output logic [AW-1:0] a,
                            output logic d, output string tag);
      c   = 4'b0111;
      a   = '0;
      d   = (i >= DONE_AT);
      tag = (i >= DONE_AT) ? "R7" : ((i < W_EXP) ? "R2" : "R4");
      if (i == W_EXP) begin
         c = 4'b0010; a = AW'(1) << 10; tag = "R3";
      end else if (i == MRS_AT) begin
         c = 4'b0000; a = MODEV; tag = "R6";
      end else begin
         for (int k = 0; k < int'(NREF); k++) begin
            if (i == W_EXP + RP_EXP + k * RC_EXP) begin
               c = 4'b0001; tag = "R5";
            end
         end
      end
      if (i == 0) tag = "R1";
   endtask

   // compare on every cycle, away from the clock edge
   always @(negedge clk) begin
      logic [3:0] ec;
      logic [AW-1:0] ea;
      logic ed;
      string tg;
      if (armed && reset_seen) begin
         expect_at(idx, ec, ea, ed, tg);
         checks++;
         if ({cs_n, ras_n, cas_n, we_n} !== ec || addr !== ea || ba !== 2'b00 || done !== ed) begin
            errors++;
            $display("FAIL %s idx=%0d: cmd=%b addr=%h ba=%b done=%b, expected cmd=%b addr=%h ba=00 done=%b",
                     tg, idx, {cs_n, ras_n, cas_n, we_n}, addr, ba, done, ec, ea, ed);
         end
         checks++;
         if (cke !== 1'b1 || dqm !== 2'b11) begin
            errors++;
            $display("FAIL R8 idx=%0d: cke=%b dqm=%b, expected cke=1 dqm=11", idx, cke, dqm);
         end
      end
   end

   task automatic run_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_reset(input int n);
      @(negedge clk);
      rst = 1'b1;
      run_cycles(n);
      rst = 1'b0;
   endtask

   initial begin
      // R1: reset held, then released
      rst = 1'b1;
      run_cycles(4);
      rst = 1'b0;
      // full sequence, R2..R8, then linger on done
      run_cycles(DONE_AT + 40);
      // R9: reset after done clears it and restarts
      pulse_reset(2);
      run_cycles(W_EXP + RP_EXP + 3 * RC_EXP + 2);
      // R9: reset in the middle of the refresh train
      pulse_reset(3);
      run_cycles(DONE_AT + 20);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule